// File: doc/BRIEF.md
# Precise Exception Prioritizer

This block sits beside a four-stage-deep instruction pipeline (fetch, decode, execute, memory) and decides, every cycle, whether control must leave the running program. Each stage reports whether the instruction it currently holds has faulted. Fetch and memory also report what kind of fault it was. An external interrupt line can request entry as well. The block takes the request of the oldest instruction and produces several results in the same cycle: a one-cycle redirect with a vectored handler address, flush controls for the faulting stage and every younger stage, and a write-suppress for the faulting instruction. Older instructions run on to completion.

When a redirect is accepted, the block captures the faulting program counter and a cause code. Both are held until the next accepted entry. The block also keeps a short record of which stages were flushed, so that a killed instruction moving down the pipe as a bubble cannot raise a second, stale exception. An interrupt is attached to the instruction in decode. It is taken only when no instruction exception is pending.

Top module: `exc_prioritizer`

## Requirements
- R1: While reset is asserted, and right after it, redirect, flush and write-suppress are low, and the saved PC and cause read zero, whatever the request inputs show.
- R2: flush_o bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory. An accepted instruction exception from stage k sets flush bits 0..k and clears the bits above k. With no redirect, flush_o is zero.
- R3: When several unmasked stages raise exceptions in the same cycle, the stage holding the oldest instruction wins. Memory beats execute, execute beats decode, and decode beats fetch. The winner's PC is the one saved.
- R4: Cause codes: 0 undefined opcode (decode), 1 arithmetic overflow (execute), 2 external interrupt, 3/4/5 fetch page fault / misaligned / protection, 6/7/8 data page fault / misaligned / protection. The kind input encodes 0 page fault, 1 misaligned, and 2 or 3 protection.
- R5: The handler address is 0xC0000000 plus 0x20 times the cause code. It is driven only while redirect is high and is zero otherwise.
- R6: Write-suppress is high in exactly the cycles where an instruction exception is accepted. It is low for an interrupt entry.
- R7: An interrupt is taken only when no unmasked instruction exception is present and decode holds a valid, unflushed instruction. It saves the decode PC with cause 2 and flushes fetch and decode.
- R8: Redirect, flush and handler respond in the same cycle as the request. The saved PC and cause load at the end of that cycle and keep their values until the next accepted entry.
- R9: A stage that was flushed in one cycle hands a bubble to the next stage down. Any request that next stage raises in the following cycle is ignored and produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_exc_i | input | 1 | Fetch instruction faulted |
| if_kind_i | input | 2 | Fetch fault kind |
| if_pc_i | input | 32 | PC of the fetch-stage instruction |
| id_vld_i | input | 1 | Decode stage holds a real instruction |
| id_exc_i | input | 1 | Decode found an undefined opcode |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_exc_i | input | 1 | Execute raised an arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| mem_exc_i | input | 1 | Memory access faulted |
| mem_kind_i | input | 2 | Memory fault kind |
| mem_pc_i | input | 32 | PC of the memory-stage instruction |
| irq_i | input | 1 | External interrupt request |
| flush_o | output | 4 | Per-stage flush, bit 0 fetch to bit 3 memory |
| wr_suppress_o | output | 1 | Block register write of the faulting instruction |
| redirect_o | output | 1 | Steer fetch to handler_o this cycle |
| handler_o | output | 32 | Vectored handler address |
| epc_o | output | 32 | Saved exception PC |
| cause_o | output | 4 | Saved cause code |

## Verification
The hardest case to reach from the ports is a stale request: a stage whose instruction was killed the cycle before still raises its flag. A pipeline that is slow to clear its stage valids would do exactly this. The stimulus produces it by holding the execute and memory request lines high for the cycle right after a decode or execute entry, and then checks that no second redirect appears. Interrupt entry is also driven in the cycle after a fetch flush, when decode holds only a bubble, to confirm that the interrupt waits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NST = 4;
  localparam int CW  = 4;

  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;

  typedef enum logic [CW-1:0] {
    C_UNDEF = 4'd0,
    C_OVF   = 4'd1,
    C_IRQ   = 4'd2,
    C_IPF   = 4'd3,
    C_IMIS  = 4'd4,
    C_IPROT = 4'd5,
    C_DPF   = 4'd6,
    C_DMIS  = 4'd7,
    C_DPROT = 4'd8
  } cause_e;

  function automatic cause_e fetch_cause(input logic [1:0] kind);
    case (kind)
      2'd0:    return C_IPF;
      2'd1:    return C_IMIS;
      default: return C_IPROT;
    endcase
  endfunction

  function automatic cause_e data_cause(input logic [1:0] kind);
    case (kind)
      2'd0:    return C_DPF;
      2'd1:    return C_DMIS;
      default: return C_DPROT;
    endcase
  endfunction
endpackage

// File: rtl/exc_kill_track.sv
module exc_kill_track #(
  parameter int NST = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NST-2:0] flush_i,
  output logic [NST-1:1] kill_o
);
  for (genvar s = 1; s < NST; s++) begin : g_kill
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kill_o[s] <= 1'b0;
      else        kill_o[s] <= flush_i[s-1];
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NST = 4
) (
  input  logic [NST-1:0] req_i,
  output logic [NST-1:0] win_o,
  output logic [NST-1:0] flush_o,
  output logic           any_o
);
  logic [NST-1:0] older_req;
  logic [NST-1:0] win_or_older;

  assign older_req[NST-1] = 1'b0;
  for (genvar s = 0; s < NST - 1; s++) begin : g_older
    assign older_req[s] = older_req[s+1] | req_i[s+1];
  end

  for (genvar s = 0; s < NST; s++) begin : g_win
    assign win_o[s] = req_i[s] & ~older_req[s];
  end

  assign win_or_older[NST-1] = win_o[NST-1];
  for (genvar s = 0; s < NST - 1; s++) begin : g_flush
    assign win_or_older[s] = win_or_older[s+1] | win_o[s];
  end

  assign flush_o = win_or_older;
  assign any_o   = |req_i;
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int PC_W = 32,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PC_W-1:0] epc_d,
  input  logic [CW-1:0]   cause_d,
  output logic [PC_W-1:0] epc_q,
  output logic [CW-1:0]   cause_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (load_i) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  // R8: values are captured at the accepting edge
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (epc_q == $past(epc_d)) && (cause_q == $past(cause_d)));

  // R8: values hold between accepted entries
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(epc_q) && $stable(cause_q));
endmodule

// File: rtl/exc_prioritizer.sv
module exc_prioritizer
  import exc_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter logic [31:0] VEC_BASE  = 32'hC000_0000,
  parameter int          VEC_SHIFT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_exc_i,
  input  logic [1:0]      if_kind_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic            id_vld_i,
  input  logic            id_exc_i,
  input  logic [PC_W-1:0] id_pc_i,
  input  logic            ex_exc_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            mem_exc_i,
  input  logic [1:0]      mem_kind_i,
  input  logic [PC_W-1:0] mem_pc_i,
  input  logic            irq_i,
  output logic [3:0]      flush_o,
  output logic            wr_suppress_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] handler_o,
  output logic [PC_W-1:0] epc_o,
  output logic [3:0]      cause_o
);
  localparam logic [NST-1:0] IRQ_FLUSH = {{(NST-2){1'b0}}, 2'b11};

  function automatic logic [PC_W-1:0] vec_of(input logic [CW-1:0] c);
    return PC_W'(VEC_BASE) + (PC_W'(c) << VEC_SHIFT);
  endfunction

  // named internal events
  logic [NST-1:1]  kill;
  logic [NST-1:0]  raw_req;
  logic [NST-1:0]  req;
  logic [NST-1:0]  win;
  logic [NST-1:0]  arb_flush;
  logic            inst_take;
  logic            irq_take;
  logic            accept;
  logic [PC_W-1:0] stage_pc    [NST];
  cause_e          stage_cause [NST];
  logic [PC_W-1:0] win_pc;
  cause_e          win_cause;
  logic [PC_W-1:0] epc_sel;
  logic [CW-1:0]   cause_sel;

  assign raw_req[ST_IF]  = if_exc_i;
  assign raw_req[ST_ID]  = id_exc_i;
  assign raw_req[ST_EX]  = ex_exc_i;
  assign raw_req[ST_MEM] = mem_exc_i;

  assign stage_pc[ST_IF]  = if_pc_i;
  assign stage_pc[ST_ID]  = id_pc_i;
  assign stage_pc[ST_EX]  = ex_pc_i;
  assign stage_pc[ST_MEM] = mem_pc_i;

  assign stage_cause[ST_IF]  = fetch_cause(if_kind_i);
  assign stage_cause[ST_ID]  = C_UNDEF;
  assign stage_cause[ST_EX]  = C_OVF;
  assign stage_cause[ST_MEM] = data_cause(mem_kind_i);

  // fetch is never masked: the next fetch after a redirect is the handler
  assign req[0] = raw_req[0] & rst_n;
  for (genvar s = 1; s < NST; s++) begin : g_mask
    assign req[s] = raw_req[s] & ~kill[s] & rst_n;
  end

  exc_arbiter #(.NST(NST)) u_arb (
    .req_i   (req),
    .win_o   (win),
    .flush_o (arb_flush),
    .any_o   (inst_take)
  );

  always_comb begin
    win_pc    = '0;
    win_cause = C_UNDEF;
    for (int s = 0; s < NST; s++) begin
      if (win[s]) begin
        win_pc    = stage_pc[s];
        win_cause = stage_cause[s];
      end
    end
  end

  assign irq_take = rst_n & irq_i & id_vld_i & ~kill[ST_ID] & ~inst_take;
  assign accept   = inst_take | irq_take;

  assign epc_sel   = inst_take ? win_pc : id_pc_i;
  assign cause_sel = inst_take ? CW'(win_cause) : CW'(C_IRQ);

  always_comb begin
    if (inst_take)     flush_o = arb_flush;
    else if (irq_take) flush_o = IRQ_FLUSH;
    else               flush_o = '0;
  end

  assign wr_suppress_o = inst_take;
  assign redirect_o    = accept;
  assign handler_o     = accept ? vec_of(cause_sel) : '0;

  exc_kill_track #(.NST(NST)) u_kill (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_o[NST-2:0]),
    .kill_o  (kill)
  );

  exc_state #(.PC_W(PC_W), .CW(CW)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .epc_d   (epc_sel),
    .cause_d (cause_sel),
    .epc_q   (epc_o),
    .cause_q (cause_o)
  );

  // R2: a redirect flushes a contiguous run starting at fetch
  a_r2_flush_shape: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> flush_o[0] && ((flush_o & (flush_o + 4'd1)) == 4'd0));

  // R2: nothing is flushed without a redirect
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> (flush_o == 4'd0) && !wr_suppress_o);

  // R3: an unmasked memory-stage request always flushes memory
  a_r3_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_exc_i && !kill[ST_MEM]) |-> flush_o[ST_MEM]);

  // R6: suppress only with an instruction entry, never for an interrupt
  a_r6_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    wr_suppress_o |-> redirect_o && (cause_sel != CW'(C_IRQ)));

  // R7: interrupt entry flushes only fetch and decode
  a_r7_irq_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !wr_suppress_o) |-> (flush_o == IRQ_FLUSH));

  // R9: an instruction flushed out of execute cannot fault in memory
  a_r9_no_refault: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_o[ST_EX]) |-> !flush_o[ST_MEM]);
endmodule

// File: tb/sim_exc_prioritizer.sv
module sim_exc_prioritizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_exc = 0, id_vld = 0, id_exc = 0, ex_exc = 0, mem_exc = 0, irq = 0;
  logic [1:0]  if_kind = 0, mem_kind = 0;
  logic [31:0] if_pc = 0, id_pc = 0, ex_pc = 0, mem_pc = 0;
  logic [3:0]  flush;
  logic        sup, redir;
  logic [31:0] hnd, epc;
  logic [3:0]  cause;

  always #4 clk = ~clk;

  exc_prioritizer u0 (
    .clk(clk), .rst_n(rst_n),
    .if_exc_i(if_exc), .if_kind_i(if_kind), .if_pc_i(if_pc),
    .id_vld_i(id_vld), .id_exc_i(id_exc), .id_pc_i(id_pc),
    .ex_exc_i(ex_exc), .ex_pc_i(ex_pc),
    .mem_exc_i(mem_exc), .mem_kind_i(mem_kind), .mem_pc_i(mem_pc),
    .irq_i(irq),
    .flush_o(flush), .wr_suppress_o(sup), .redirect_o(redir),
    .handler_o(hnd), .epc_o(epc), .cause_o(cause)
  );

  typedef struct packed {
    logic        redir;
    logic [3:0]  fl;
    logic        sup;
    logic [31:0] hnd;
    logic [31:0] epc;
    logic [3:0]  cause;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  // reference state kept by the bench
  logic [3:0]  m_kill = 0;
  logic [31:0] m_epc = 0;
  logic [3:0]  m_cause = 0;

  function automatic logic [3:0] kind_code(input logic [1:0] k, input logic [3:0] base);
    return base + ((k == 2'd3) ? 4'd2 : {2'b00, k});
  endfunction

  task automatic step(input logic ife, input logic [1:0] ifk, input logic [31:0] ifp,
                      input logic idv, input logic ide, input logic [31:0] idp,
                      input logic exe, input logic [31:0] exp_pc,
                      input logic meme, input logic [1:0] memk, input logic [31:0] memp,
                      input logic irqv, input string tag);
    exp_t e;
    logic [3:0] c;
    logic [31:0] p;
    @(posedge clk);
    #1;
    if_exc = ife; if_kind = ifk; if_pc = ifp;
    id_vld = idv; id_exc = ide; id_pc = idp;
    ex_exc = exe; ex_pc = exp_pc;
    mem_exc = meme; mem_kind = memk; mem_pc = memp;
    irq = irqv;
    e = '0;
    c = 0; p = 0;
    if (meme && !m_kill[3]) begin
      e.redir = 1; e.fl = 4'b1111; e.sup = 1; c = kind_code(memk, 4'd6); p = memp;
    end else if (exe && !m_kill[2]) begin
      e.redir = 1; e.fl = 4'b0111; e.sup = 1; c = 4'd1; p = exp_pc;
    end else if (ide && !m_kill[1]) begin
      e.redir = 1; e.fl = 4'b0011; e.sup = 1; c = 4'd0; p = idp;
    end else if (ife) begin
      e.redir = 1; e.fl = 4'b0001; e.sup = 1; c = kind_code(ifk, 4'd3); p = ifp;
    end else if (irqv && idv && !m_kill[1]) begin
      e.redir = 1; e.fl = 4'b0011; e.sup = 0; c = 4'd2; p = idp;
    end
    e.hnd   = e.redir ? (32'hC000_0000 + 32'(c) * 32'h20) : 32'h0;
    e.epc   = m_epc;
    e.cause = m_cause;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (e.redir) begin
      m_epc = p;
      m_cause = c;
    end
    m_kill = {e.fl[2:0], 1'b0};
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compares mid-cycle, away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      exp_t a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{redir, flush, sup, hnd, epc, cause};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got redir=%b flush=%b sup=%b hnd=%h epc=%h cause=%0d expected redir=%b flush=%b sup=%b hnd=%h epc=%h cause=%0d",
                 t, a.redir, a.fl, a.sup, a.hnd, a.epc, a.cause,
                 e.redir, e.fl, e.sup, e.hnd, e.epc, e.cause);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: requests during reset are ignored
    mem_exc = 1; ex_exc = 1; irq = 1; id_vld = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (redir !== 0 || flush !== 0 || sup !== 0 || epc !== 0 || cause !== 0) begin
      n_bad++;
      $display("FAIL R1: got redir=%b flush=%b sup=%b epc=%h cause=%0d expected all zero",
               redir, flush, sup, epc, cause);
    end
    mem_exc = 0; ex_exc = 0; irq = 0; id_vld = 0;
    @(posedge clk);
    #1 rst_n = 1;

    idle("R1");
    step(0,0,32'h208, 1,1,32'h204, 0,0, 0,0,0, 0, "R4 undefined opcode");
    step(0,0,32'h20C, 1,1,32'h208, 1,32'h204, 0,0,0, 0, "R9 flushed decode/execute");
    step(0,0,0, 0,0,0, 1,32'h300, 0,0,0, 0, "R5 overflow vector");
    step(0,0,0, 0,0,0, 1,32'h304, 1,0,32'h300, 0, "R9 flushed execute/memory");
    step(0,0,0, 0,0,0, 0,0, 1,1,32'h400, 0, "R4 data misaligned");
    idle("R8 hold");
    step(1,0,32'h10C, 1,1,32'h108, 1,32'h104, 1,2,32'h100, 1, "R3 all stages");
    idle("R8 load");
    idle("R8 hold");
    step(1,1,32'h50C, 1,1,32'h508, 1,32'h504, 0,0,0, 0, "R3 execute oldest");
    idle("R2 gap");
    step(1,0,32'h700, 0,0,0, 0,0, 0,0,0, 0, "R2 fetch only");
    step(0,0,0, 1,0,32'h700, 0,0, 0,0,0, 1, "R7 bubble in decode");
    step(0,0,0, 1,0,32'h800, 0,0, 0,0,0, 1, "R7 interrupt taken");
    idle("R6 gap");
    step(0,0,0, 1,0,32'h904, 1,32'h900, 0,0,0, 1, "R6 exception beats interrupt");
    idle("R7 gap");
    step(0,0,0, 0,0,32'hA00, 0,0, 0,0,0, 1, "R7 no decode instruction");
    step(1,2,32'hB00, 0,0,0, 0,0, 0,0,0, 0, "R4 fetch protection");
    step(0,0,0, 0,0,0, 0,0, 1,0,32'hC00, 0, "R4 data page fault");
    idle("R8 gap");
    step(0,0,0, 0,0,0, 0,0, 1,3,32'hD00, 0, "R4 data protection kind 3");
    step(1,1,32'hE00, 0,0,0, 0,0, 0,0,0, 0, "R4 fetch misaligned");
    idle("R8 final");
    idle("R8 final");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule